// File: doc/BRIEF.md
# TDM Serial Output Framer

The block takes words from a small internal buffer and shifts them out on a single serial data line. The serial clock runs all the time. Each transfer is marked by a frame strobe that comes one clock ahead of the first data bit. A frame is a programmed number of word slots long. Only the first few slots carry data. For the rest of the frame the data line is released, which the block shows as a low output enable.

Several framers can share one time-division-multiplexed line. The master starts every frame. It emits a one-clock ready pulse together with its strobe and drives the opening words. A slave takes that ready pulse as its input. It counts off a programmed number of word slots, then drives its own block of words. A framer starts a transfer only when a complete block of words is waiting in its buffer. Words that arrive while a frame is in progress are held until they are needed.

The strobe can mark the whole block, every second word (for complex pairs, where one sample takes two consecutive words), or every word. Its polarity is selectable.

Top module: `tdm_serial_framer`

## Requirements
- R1: After reset, `sd_oe` and `sd_out` are 0, `rdy_out` is 0, `fs_out` sits at its inactive level (equal to `cfg_strobe_inv`), and `in_ready` is 1.
- R2: A master starts a transfer only when the buffer holds at least `cfg_words_m1`+1 words. While it holds fewer, the strobe stays inactive and `sd_oe` stays low. When the last needed word is accepted at clock edge P, the strobe is active in the cycle after edge P+1.
- R3: The strobe is active for exactly one clock. The first data bit follows in the next clock. In master mode `rdy_out` pulses high in the same cycle as each frame-start strobe.
- R4: Each word is `WORD_W` bits, sent MSB first, one bit per clock. The words of a block follow each other with no gap, in the order they were accepted, and `sd_oe` is 1 for every data bit.
- R5: A master frame lasts `cfg_frame_m1`+1 word slots. After the `cfg_words_m1`+1 active words, `sd_oe` and `sd_out` are 0 for the remaining slots.
- R6: If a full block is present when a master frame ends, the next strobe falls in the same cycle as the last bit slot of the ending frame. Otherwise the master waits in idle with the strobe inactive.
- R7: `cfg_strobe_mode` 0 gives one strobe per block. Mode 1 also strobes one clock before words 2, 4, 6 and so on, counting from 0. Mode 2 strobes one clock before every word of the block. Mode 3 behaves as mode 0.
- R8: With `cfg_strobe_inv` = 1, `fs_out` is high when inactive and low for a strobe.
- R9: A slave ignores the buffer until `rdy_in` is seen high. If `rdy_in` is high in cycle T, the slave strobe comes in cycle T + (`cfg_frame_m1`+1)·`WORD_W`, with data from the next cycle on. A slave never raises `rdy_out`.
- R10: If a slave lacks a full block when its slot arrives, it sends nothing in that frame: no strobe and no output enable. It waits for the next `rdy_in`.
- R11: The buffer holds `FIFO_DEPTH` words. `in_ready` is 1 while fewer are stored. A word offered while `in_ready` is 0 is dropped, and stored words are never lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all logic on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | WORD_W | Word offered to the buffer |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Buffer has room; a word is taken when valid and ready are both high |
| cfg_master | input | 1 | 1 = master (generates frames), 0 = slave (follows `rdy_in`) |
| cfg_words_m1 | input | ACT_W | Active words per block, minus one |
| cfg_frame_m1 | input | FRM_W | Master: frame length in words minus one. Slave: start slot minus one |
| cfg_strobe_mode | input | 2 | 0 per block, 1 per word pair, 2 per word |
| cfg_strobe_inv | input | 1 | Invert strobe polarity |
| rdy_in | input | 1 | Start-of-frame pulse from the master (used in slave mode) |
| rdy_out | output | 1 | Start-of-frame pulse (master mode) |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Data line driven; low means released |
| fs_out | output | 1 | Frame strobe, polarity per `cfg_strobe_inv` |

## Verification
The bit and word counters decide where the strobe falls and when the enable drops. An off-by-one in either moves the strobe or the enable edge by one clock at the first word boundary. The bench sees this in the same clock, because it checks strobe placement on every bit of every word. If the buffer count goes wrong, a frame starts one clock early or late after the last push, or sends a word out of order, and the first word compare of that block catches it. If the slave delay counter goes wrong, the slave strobe lands away from slot (`cfg_frame_m1`+1)·`WORD_W` after `rdy_in`, and this is caught at that exact clock.

// File: rtl/tdm_framer_pkg.sv
package tdm_framer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_SEND  = 2'd2
    } phase_e;

    localparam logic [1:0] STB_BLOCK = 2'd0;
    localparam logic [1:0] STB_PAIR  = 2'd1;
    localparam logic [1:0] STB_WORD  = 2'd2;

endpackage

// File: rtl/tdm_word_fifo.sv
module tdm_word_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              full
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic do_push;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign head    = mem_q[st_q.rd];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = st_q.wr + 1'b1;
        if (pop)     st_d.rd = st_q.rd + 1'b1;
        case ({do_push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0);  // R11
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));  // R11

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_framer_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_ACT   = 8,
    parameter int MAX_FRAME = 64,
    parameter int CNT_W     = 5,
    localparam int ACT_W    = $clog2(MAX_ACT),
    localparam int FRM_W    = $clog2(MAX_FRAME),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int DLY_W    = FRM_W + BIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic [ACT_W-1:0]  cfg_words_m1,
    input  logic [FRM_W-1:0]  cfg_frame_m1,
    input  logic [1:0]        cfg_strobe_mode,
    input  logic              rdy_in,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic              sd,
    output logic              oe,
    output logic              fs,
    output logic              rdy
);

    typedef struct packed {
        phase_e            phase;
        logic [BIT_W-1:0]  bit_i;
        logic [FRM_W-1:0]  word_i;
        logic [DLY_W-1:0]  dly;
        logic [WORD_W-1:0] shreg;
        logic              sd;
        logic              oe;
        logic              fs;
        logic              rdy;
    } ctrl_st_t;

    ctrl_st_t q, d;

    logic             block_ok;
    logic             last_bit;
    logic             active;
    logic [FRM_W-1:0] act_last;
    logic             mid_strobe;

    assign act_last   = FRM_W'(cfg_words_m1);
    assign block_ok   = int'(fifo_cnt) >= int'(cfg_words_m1) + 1;
    assign last_bit   = (q.bit_i == BIT_W'(WORD_W - 1));
    assign active     = (q.word_i <= act_last);
    assign mid_strobe = (q.word_i < act_last) &&
                        ((cfg_strobe_mode == STB_WORD) ||
                         (cfg_strobe_mode == STB_PAIR && q.word_i[0]));

    always_comb begin
        d        = q;
        d.sd     = 1'b0;
        d.oe     = 1'b0;
        d.fs     = 1'b0;
        d.rdy    = 1'b0;
        fifo_pop = 1'b0;

        case (q.phase)
            PH_IDLE: begin
                if (cfg_master) begin
                    if (block_ok) begin
                        d.phase  = PH_SEND;
                        d.bit_i  = '0;
                        d.word_i = '0;
                        d.fs     = 1'b1;
                        d.rdy    = 1'b1;
                    end
                end else if (rdy_in) begin
                    d.phase = PH_DELAY;
                    d.dly   = DLY_W'((int'(cfg_frame_m1) + 1) * WORD_W - 2);
                end
            end
            PH_DELAY: begin
                if (q.dly == '0) begin
                    if (block_ok) begin
                        d.phase  = PH_SEND;
                        d.bit_i  = '0;
                        d.word_i = '0;
                        d.fs     = 1'b1;
                    end else begin
                        d.phase = PH_IDLE;
                    end
                end else begin
                    d.dly = q.dly - 1'b1;
                end
            end
            PH_SEND: begin
                if (active) begin
                    d.oe = 1'b1;
                    if (q.bit_i == '0) begin
                        fifo_pop = 1'b1;
                        d.sd     = fifo_head[WORD_W-1];
                        d.shreg  = fifo_head << 1;
                    end else begin
                        d.sd     = q.shreg[WORD_W-1];
                        d.shreg  = q.shreg << 1;
                    end
                end
                if (last_bit) begin
                    d.bit_i  = '0;
                    d.word_i = q.word_i + 1'b1;
                    if (!cfg_master && q.word_i == act_last) begin
                        d.phase = PH_IDLE;
                    end else if (cfg_master && q.word_i == cfg_frame_m1) begin
                        d.phase = PH_IDLE;
                        if (block_ok) begin
                            d.phase  = PH_SEND;
                            d.word_i = '0;
                            d.fs     = 1'b1;
                            d.rdy    = 1'b1;
                        end
                    end else if (mid_strobe) begin
                        d.fs = 1'b1;
                    end
                end else begin
                    d.bit_i = q.bit_i + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sd  = q.sd;
    assign oe  = q.oe;
    assign fs  = q.fs;
    assign rdy = q.rdy;

    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        q.fs |=> !q.fs);  // R3
    AST_STROBE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.fs |=> q.oe);  // R3
    AST_READY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |-> q.fs);  // R3
    AST_SLAVE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |-> $past(cfg_master));  // R9
    AST_RELEASED_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe |-> !q.sd);  // R5

endmodule

// File: rtl/tdm_serial_framer.sv
module tdm_serial_framer #(
    parameter int WORD_W     = 16,
    parameter int MAX_ACT    = 8,
    parameter int MAX_FRAME  = 64,
    parameter int FIFO_DEPTH = 16,
    localparam int ACT_W     = $clog2(MAX_ACT),
    localparam int FRM_W     = $clog2(MAX_FRAME),
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_master,
    input  logic [ACT_W-1:0]  cfg_words_m1,
    input  logic [FRM_W-1:0]  cfg_frame_m1,
    input  logic [1:0]        cfg_strobe_mode,
    input  logic              cfg_strobe_inv,
    input  logic              rdy_in,
    output logic              rdy_out,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              fs_out
);

    logic              pop;
    logic              full;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  cnt;
    logic              fs_raw;

    tdm_word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_data (in_data),
        .pop       (pop),
        .head      (head),
        .count     (cnt),
        .full      (full)
    );

    tdm_frame_ctrl #(
        .WORD_W    (WORD_W),
        .MAX_ACT   (MAX_ACT),
        .MAX_FRAME (MAX_FRAME),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_master      (cfg_master),
        .cfg_words_m1    (cfg_words_m1),
        .cfg_frame_m1    (cfg_frame_m1),
        .cfg_strobe_mode (cfg_strobe_mode),
        .rdy_in          (rdy_in),
        .fifo_cnt        (cnt),
        .fifo_head       (head),
        .fifo_pop        (pop),
        .sd              (sd_out),
        .oe              (sd_oe),
        .fs              (fs_raw),
        .rdy             (rdy_out)
    );

    assign in_ready = !full;
    assign fs_out   = fs_raw ^ cfg_strobe_inv;

endmodule

// File: tb/tdm_serial_framer_test.sv
module tdm_serial_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         cfg_master = 1'b0;
    logic [2:0]   cfg_words_m1 = '0;
    logic [5:0]   cfg_frame_m1 = '0;
    logic [1:0]   cfg_strobe_mode = '0;
    logic         cfg_strobe_inv = 1'b0;
    logic         rdy_in = 1'b0;
    logic         rdy_out, sd_out, sd_oe, fs_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [W-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_serial_framer uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cfg_master(cfg_master), .cfg_words_m1(cfg_words_m1),
        .cfg_frame_m1(cfg_frame_m1), .cfg_strobe_mode(cfg_strobe_mode),
        .cfg_strobe_inv(cfg_strobe_inv), .rdy_in(rdy_in), .rdy_out(rdy_out),
        .sd_out(sd_out), .sd_oe(sd_oe), .fs_out(fs_out)
    );

    function automatic logic fs_act();
        return fs_out ^ cfg_strobe_inv;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; rdy_in = 1'b0;
        exp_q.delete();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push(input logic [W-1:0] v);
        in_data = v; in_valid = 1'b1;
        if (in_ready) exp_q.push_back(v);
        tick();
        in_valid = 1'b0;
    endtask

    // Starts at the strobe cycle; checks words, enable and strobe placement
    task automatic run_block(input int a, input int smode);
        for (int w = 0; w < a; w++) begin
            logic [W-1:0] got = '0;
            logic [W-1:0] exp;
            int oe_bad = 0;
            int fs_bad = 0;
            for (int b = 0; b < W; b++) begin
                bit efs;
                tick();
                got = {got[W-2:0], sd_out};
                if (!sd_oe) oe_bad++;
                efs = (b == W-1) && (w < a-1) &&
                      (smode == 2 || (smode == 1 && (w % 2) == 1));
                if (b != W-1 || w < a-1)
                    if (fs_act() != efs) fs_bad++;
            end
            exp = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
            check(got === exp, "R4 word value", got, exp);
            check(oe_bad == 0, "R4 enable during word", oe_bad, 0);
            check(fs_bad == 0, "R7 strobe placement", fs_bad, 0);
        end
    endtask

    task automatic tail(input int nclk, input bit fs_last);
        int bad = 0;
        int fbad = 0;
        for (int k = 0; k < nclk; k++) begin
            tick();
            if (sd_oe || sd_out) bad++;
            if (fs_act() != (fs_last && k == nclk-1)) fbad++;
        end
        check(bad == 0, "R5 released after active words", bad, 0);
        check(fbad == 0, "R6 strobe at frame end", fbad, 0);
    endtask

    task automatic wait_quiet(input int n, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (fs_act() || sd_oe) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic slave_kick(input int f, input bit expect_start);
        int early = 0;
        int rbad = 0;
        rdy_in = 1'b1;
        for (int k = 1; k <= f*W; k++) begin
            tick();
            if (k == 1) rdy_in = 1'b0;
            if (rdy_out) rbad++;
            if (k < f*W && (fs_act() || sd_oe)) early++;
        end
        check(early == 0, "R9 slave quiet before slot", early, 0);
        check(rbad == 0, "R9 slave rdy_out low", rbad, 0);
        check(fs_act() == expect_start, expect_start ? "R9 slave strobe at slot" : "R10 no strobe when starved",
              fs_act(), expect_start);
    endtask

    task automatic t_reset();
        cfg_master = 1'b0; cfg_strobe_inv = 1'b0;
        do_reset();
        check(sd_oe == 1'b0 && sd_out == 1'b0, "R1 data idle", {sd_oe, sd_out}, 0);
        check(fs_out == 1'b0, "R1 strobe idle", fs_out, 0);
        check(rdy_out == 1'b0, "R1 rdy_out idle", rdy_out, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_master_starved();
        cfg_master = 1'b1; cfg_words_m1 = 3'd3; cfg_frame_m1 = 6'd5; cfg_strobe_mode = 2'd0;
        do_reset();
        push(16'hA5C3); push(16'h0001); push(16'h8000);
        wait_quiet(40, "R2 no frame without full block");
        push(16'h7FFE);
        tick();
        check(fs_act() == 1'b1, "R2 strobe after block complete", fs_act(), 1);
        check(rdy_out == 1'b1, "R3 rdy_out with frame strobe", rdy_out, 1);
        run_block(4, 0);
        tail(2*W, 1'b0);
        wait_quiet(20, "R6 master waits when empty");
    endtask

    task automatic t_back_to_back();
        cfg_master = 1'b0; cfg_words_m1 = 3'd1; cfg_frame_m1 = 6'd2; cfg_strobe_mode = 2'd2;
        do_reset();
        push(16'h1234); push(16'hFEDC); push(16'h0F0F); push(16'hC001);
        cfg_master = 1'b1;
        tick();
        check(fs_act() == 1'b1 && rdy_out == 1'b1, "R3 start strobe and rdy", {fs_act(), rdy_out}, 2'b11);
        run_block(2, 2);
        tail(W, 1'b1);
        check(rdy_out == 1'b1, "R6 back-to-back rdy_out", rdy_out, 1);
        run_block(2, 2);
        tail(W, 1'b0);
        wait_quiet(20, "R6 idle after last block");
    endtask

    task automatic t_pair_inverted();
        cfg_master = 1'b0; cfg_words_m1 = 3'd5; cfg_frame_m1 = 6'd6;
        cfg_strobe_mode = 2'd1; cfg_strobe_inv = 1'b1;
        do_reset();
        check(fs_out == 1'b1, "R8 inverted idle level", fs_out, 1);
        for (int i = 0; i < 6; i++) push(16'h1111 * 16'(i + 3));
        cfg_master = 1'b1;
        tick();
        check(fs_out == 1'b0, "R8 inverted strobe low", fs_out, 0);
        run_block(6, 1);
        tail(W, 1'b0);
        cfg_strobe_inv = 1'b0;
    endtask

    task automatic t_slave();
        cfg_master = 1'b0; cfg_words_m1 = 3'd1; cfg_frame_m1 = 6'd2; cfg_strobe_mode = 2'd0;
        do_reset();
        push(16'hBEEF); push(16'h4321);
        wait_quiet(30, "R9 slave waits for rdy_in");
        slave_kick(3, 1'b1);
        run_block(2, 0);
        wait_quiet(20, "R9 slave releases after block");
        slave_kick(3, 1'b0);
        wait_quiet(3*W, "R10 starved slave stays quiet");
        push(16'h6A6A); push(16'h9595);
        slave_kick(3, 1'b1);
        run_block(2, 0);
        wait_quiet(10, "R10 slave recovers");
    endtask

    task automatic t_fifo_full();
        cfg_master = 1'b0; cfg_words_m1 = 3'd7; cfg_frame_m1 = 6'd0; cfg_strobe_mode = 2'd0;
        do_reset();
        for (int i = 0; i < 16; i++) push(16'h0100 + 16'(i));
        check(in_ready == 1'b0, "R11 in_ready low when full", in_ready, 0);
        push(16'hDEAD);
        check(exp_q.size() == 16, "R11 word dropped when full", exp_q.size(), 16);
        slave_kick(1, 1'b1);
        run_block(8, 0);
        check(in_ready == 1'b1, "R11 in_ready after drain", in_ready, 1);
        tick();
        slave_kick(1, 1'b1);
        run_block(8, 0);
        tick();
        slave_kick(1, 1'b0);
        wait_quiet(2*W, "R11 dropped word never sent");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_master_starved();
        t_back_to_back();
        t_pair_inverted();
        t_slave();
        t_fifo_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule